// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Control

This block is the digital half of a frequency synthesizer's main divider. An external prescaler divides the RF signal by either P or P+1. This block counts the prescaler's output, one strobe per prescaler cycle. It steers the prescaler's modulus through a control line and emits one divided pulse every N RF cycles, which goes to the phase detector. The prescaler size is selectable between 64/65 and 128/129.

Software supplies only the total ratio N and the prescaler size. The block splits N into a programmable count B = N div P and a swallow count A = N mod P. During the first A prescaler cycles of each output period the prescaler divides by P+1. For the remaining B−A cycles it divides by P. The total is therefore P·B + A.

A ratio is accepted only if the split works. That means either B ≥ A, or N lies at or above P·(P−1), the point above which every ratio can be built. A rejected ratio raises a flag and is never applied. An accepted ratio is held back until the current output period has ended, so no shortened period is produced.

Top module: `swallow_divider`

## Requirements
- R1: Each output period spans exactly B prescaler strobes, of which the first A are issued with `modCtl` = 1 (prescaler divides by P+1) and the rest with `modCtl` = 0 (divides by P). The period is therefore P·B + A input cycles.
- R2: A loaded ratio is split as B = N div P and A = N mod P. P is 64 when `preSel` = 0 and 128 when `preSel` = 1. Once the ratio is in force, `aVal` and `bVal` show A and B.
- R3: A ratio is legal only if 1 ≤ B ≤ 2^BW−1 and, in addition, either N ≥ P·(P−1) (4032 for P = 64, 16256 for P = 128) or B ≥ A.
- R4: `modCtl` rises only at an output-period boundary. It stays high for A strobes, including the case B = A.
- R5: When A = 0, `modCtl` stays low for the whole output period.
- R6: A legal ratio loaded mid-period does not alter that period. `aVal` and `bVal` keep their old values until the boundary, and the new A and B govern the next period.
- R7: An illegal load sets `illegal` in the cycle after `loadReq`, and leaves the active and staged ratio untouched. Only a later load changes `illegal`, and a legal one clears it.
- R8: After reset, `aVal` = RST_A (1) and `bVal` = RST_B (17), `modCtl` = 1, and `divPulse` and `illegal` are 0.
- R9: `divPulse` is high for the single clock after the strobe that ends a period, even when strobes arrive back-to-back with B = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| preStrobe | input | 1 | One-clock strobe per completed prescaler output cycle |
| nReq | input | NW (18) | Requested total divide number N |
| preSel | input | 1 | Prescaler size: 0 = 64/65, 1 = 128/129 |
| loadReq | input | 1 | Stage `nReq`/`preSel` as the next ratio |
| modCtl | output | 1 | 1 = prescaler divides by P+1, 0 = by P |
| divPulse | output | 1 | One-clock divided output pulse |
| aVal | output | AW (7) | Swallow count in force |
| bVal | output | BW (11) | Programmable count in force |
| illegal | output | 1 | Last load was rejected |

## Verification
The divider is run with a plain mixed ratio (A = 1 and 10 with B = 17), with A = 0, with A = B, and with a large ratio under the 128/129 prescaler. These cases show whether the swallow phase is placed, sized and terminated correctly, and each measured period is converted back to input cycles and compared with N. Rejection is probed on both sides of each P·(P−1) threshold, with A > B under the large prescaler, with N = 0 and with an oversized B. These cases show the legality rule is exact, and they confirm the running ratio survives a rejection. A load in the middle of a period, and back-to-back strobes with B = 1, show the boundary staging and the pulse timing.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int P_SMALL = 64;
  localparam int P_LARGE = 128;
  localparam int SH_SMALL = $clog2(P_SMALL);
  localparam int SH_LARGE = $clog2(P_LARGE);
  localparam int MIN_CONT_SMALL = P_SMALL * (P_SMALL - 1);
  localparam int MIN_CONT_LARGE = P_LARGE * (P_LARGE - 1);

  // strobes issued by the sequencer towards the ratio datapath
  typedef struct packed {
    logic wrap;   // current output period ends on this clock
  } seqStb_t;
endpackage

// File: rtl/swallow_split.sv
module swallow_split
  import swallow_pkg::*;
#(
  parameter int NW = 18,
  parameter int AW = 7,
  parameter int BW = 11
) (
  input  logic [NW-1:0] nIn,
  input  logic          bigPre,
  output logic [AW-1:0] aOut,
  output logic [BW-1:0] bOut,
  output logic          legal
);
  localparam int RAW_AW = SH_LARGE;

  logic [NW-1:0]     bFull;
  logic [RAW_AW-1:0] aRaw;
  logic [NW-1:0]     minCont;
  logic              fits, nonZero, continuous, ordered;

  always_comb begin
    if (bigPre) begin
      bFull   = nIn >> SH_LARGE;
      aRaw    = nIn[RAW_AW-1:0];
      minCont = NW'(MIN_CONT_LARGE);
    end else begin
      bFull   = nIn >> SH_SMALL;
      aRaw    = {1'b0, nIn[SH_SMALL-1:0]};
      minCont = NW'(MIN_CONT_SMALL);
    end
    fits       = (bFull >> BW) == '0;
    nonZero    = bFull != '0;
    continuous = nIn >= minCont;
    ordered    = bFull >= NW'(aRaw);
    legal      = fits && nonZero && (continuous || ordered);
    aOut       = AW'(aRaw);
    bOut       = bFull[BW-1:0];
  end
endmodule

// File: rtl/swallow_dp.sv
module swallow_dp
  import swallow_pkg::*;
#(
  parameter int AW = 7,
  parameter int BW = 11,
  parameter int RST_A = 1,
  parameter int RST_B = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadReq,
  input  logic          legalIn,
  input  logic [AW-1:0] aIn,
  input  logic [BW-1:0] bIn,
  input  seqStb_t       stb,
  output logic [AW-1:0] actA,
  output logic [BW-1:0] actB,
  output logic [AW-1:0] nextA,
  output logic [BW-1:0] nextB,
  output logic          illegal
);
  logic          pendValid;
  logic [AW-1:0] pendA;
  logic [BW-1:0] pendB;

  assign nextA = pendValid ? pendA : actA;
  assign nextB = pendValid ? pendB : actB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendA     <= '0;
      pendB     <= '0;
      actA      <= AW'(RST_A);
      actB      <= BW'(RST_B);
      illegal   <= 1'b0;
    end else begin
      if (stb.wrap) begin
        actA <= nextA;
        actB <= nextB;
      end
      if (loadReq) begin
        illegal <= !legalIn;
      end
      if (loadReq && legalIn) begin
        pendA     <= aIn;
        pendB     <= bIn;
        pendValid <= 1'b1;
      end else if (stb.wrap) begin
        pendValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_pkg::*;
#(
  parameter int AW = 7,
  parameter int BW = 11,
  parameter int RST_A = 1,
  parameter int RST_B = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          preStrobe,
  input  logic [AW-1:0] nextA,
  input  logic [BW-1:0] nextB,
  output seqStb_t       stb,
  output logic          modCtl,
  output logic          divPulse
);
  logic [AW-1:0] aCnt;
  logic [BW-1:0] bCnt;
  logic          lastStep;

  assign lastStep = bCnt <= BW'(1);
  assign stb.wrap = preStrobe && lastStep;
  assign modCtl   = aCnt != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aCnt     <= AW'(RST_A);
      bCnt     <= BW'(RST_B);
      divPulse <= 1'b0;
    end else begin
      divPulse <= stb.wrap;
      if (stb.wrap) begin
        aCnt <= nextA;
        bCnt <= nextB;
      end else if (preStrobe) begin
        bCnt <= bCnt - BW'(1);
        if (aCnt != '0) aCnt <= aCnt - AW'(1);
      end
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_pkg::*;
#(
  parameter int NW = 18,
  parameter int AW = 7,
  parameter int BW = 11,
  parameter int RST_A = 1,
  parameter int RST_B = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          preStrobe,
  input  logic [NW-1:0] nReq,
  input  logic          preSel,
  input  logic          loadReq,
  output logic          modCtl,
  output logic          divPulse,
  output logic [AW-1:0] aVal,
  output logic [BW-1:0] bVal,
  output logic          illegal
);
  logic [AW-1:0] splitA, nextA;
  logic [BW-1:0] splitB, nextB;
  logic          splitLegal;
  seqStb_t       stb;

  swallow_split #(.NW(NW), .AW(AW), .BW(BW)) u_split (
    .nIn(nReq), .bigPre(preSel), .aOut(splitA), .bOut(splitB), .legal(splitLegal)
  );

  swallow_dp #(.AW(AW), .BW(BW), .RST_A(RST_A), .RST_B(RST_B)) u_dp (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .legalIn(splitLegal),
    .aIn(splitA), .bIn(splitB), .stb(stb), .actA(aVal), .actB(bVal),
    .nextA(nextA), .nextB(nextB), .illegal(illegal)
  );

  swallow_ctrl #(.AW(AW), .BW(BW), .RST_A(RST_A), .RST_B(RST_B)) u_ctrl (
    .clk(clk), .rstN(rstN), .preStrobe(preStrobe), .nextA(nextA), .nextB(nextB),
    .stb(stb), .modCtl(modCtl), .divPulse(divPulse)
  );
endmodule

// File: rtl/swallow_chk.sv
module swallow_chk #(
  parameter int AW = 7,
  parameter int BW = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic          preStrobe,
  input logic          loadReq,
  input logic          modCtl,
  input logic          divPulse,
  input logic [AW-1:0] aVal,
  input logic [BW-1:0] bVal,
  input logic          illegal
);
  a_r4_mod_rises_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtl) |-> divPulse);

  a_r9_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> $past(preStrobe));

  a_r6_ratio_moves_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$past(preStrobe) |-> ($stable(aVal) && $stable(bVal)));

  a_r7_flag_moves_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadReq) |-> $stable(illegal));

  a_r5_no_swallow_without_a: assert property (@(posedge clk) disable iff (!rstN)
    modCtl |-> (aVal != '0));

  a_r3_b_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    bVal != '0);
endmodule

bind swallow_divider swallow_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rstN(rstN), .preStrobe(preStrobe), .loadReq(loadReq),
  .modCtl(modCtl), .divPulse(divPulse), .aVal(aVal), .bVal(bVal), .illegal(illegal)
);

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int NW = 18;
  localparam int AW = 7;
  localparam int BW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          preStrobe = 1'b0;
  logic [NW-1:0] nReq = '0;
  logic          preSel = 1'b0;
  logic          loadReq = 1'b0;
  logic          modCtl, divPulse, illegal;
  logic [AW-1:0] aVal;
  logic [BW-1:0] bVal;

  int checks = 0, fails = 0, cyc = 0;
  int strbCnt = 0, hiCnt = 0, lastA = 0, lastB = 0, nPulses = 0;
  int aAtPulse = 0, bAtPulse = 0;

  always #10 clk = ~clk;

  swallow_divider u_swallow_divider (
    .clk(clk), .rstN(rstN), .preStrobe(preStrobe), .nReq(nReq), .preSel(preSel),
    .loadReq(loadReq), .modCtl(modCtl), .divPulse(divPulse), .aVal(aVal),
    .bVal(bVal), .illegal(illegal)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: record the output seen now, then drive the next inputs
  task automatic tick(bit s, bit ld);
    @(negedge clk);
    if (divPulse) begin
      lastA = hiCnt; lastB = strbCnt; strbCnt = 0; hiCnt = 0; nPulses++;
      aAtPulse = int'(aVal); bAtPulse = int'(bVal);
    end
    if (s) begin
      strbCnt++;
      if (modCtl) hiCnt++;
    end
    preStrobe = s;
    loadReq = ld;
  endtask

  task automatic waitPulses(int n, int gap);
    int target = nPulses + n;
    while (nPulses < target) begin
      tick(1'b1, 1'b0);
      repeat (gap) tick(1'b0, 1'b0);
    end
  endtask

  task automatic loadN(bit sel, int n);
    preSel = sel;
    nReq = NW'(n);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
  endtask

  // finish the running period, then measure one full period
  task automatic measure(string req, int p, int n, int expA, int expB, int gap);
    waitPulses(1, gap);
    waitPulses(1, gap);
    check(req, "swallow strobes", lastA, expA);
    check(req, "strobes per period", lastB, expB);
    check(req, "aVal", aAtPulse, expA);
    check(req, "bVal", bAtPulse, expB);
    check("R1", "input cycles per period", lastA * (p + 1) + (lastB - lastA) * p, n);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(1'b0, 1'b0);
    check("R8", "aVal", int'(aVal), 1);
    check("R8", "bVal", int'(bVal), 17);
    check("R8", "modCtl", int'(modCtl), 1);
    check("R8", "divPulse", int'(divPulse), 0);
    check("R8", "illegal", int'(illegal), 0);
  endtask

  task automatic testMidLoad();
    waitPulses(1, 1);
    repeat (5) begin tick(1'b1, 1'b0); tick(1'b0, 1'b0); end
    loadN(1'b0, 1098);
    check("R6", "aVal held after load", int'(aVal), 1);
    check("R6", "bVal held after load", int'(bVal), 17);
    check("R7", "legal load flag", int'(illegal), 0);
    waitPulses(1, 1);
    check("R6", "old swallow count kept", lastA, 1);
    check("R6", "old period kept", lastB, 17);
    check("R6", "aVal switched at boundary", aAtPulse, 10);
    waitPulses(1, 1);
    check("R2", "A of 1098/64", lastA, 10);
    check("R2", "B of 1098/64", lastB, 17);
    check("R1", "input cycles 1098", lastA * 65 + (lastB - lastA) * 64, 1098);
  endtask

  task automatic testPulseTiming();
    waitPulses(1, 1);
    repeat (16) begin tick(1'b1, 1'b0); tick(1'b0, 1'b0); end
    check("R9", "no pulse before last strobe", int'(divPulse), 0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check("R9", "pulse after last strobe", int'(divPulse), 1);
    tick(1'b0, 1'b0);
    check("R9", "pulse lasts one clock", int'(divPulse), 0);
  endtask

  task automatic testIllegal(string req, bit sel, int n);
    int a0 = int'(aVal);
    int b0 = int'(bVal);
    loadN(sel, n);
    check(req, "illegal flag", int'(illegal), 1);
    check("R7", "aVal kept", int'(aVal), a0);
    check("R7", "bVal kept", int'(bVal), b0);
  endtask

  initial begin
    testReset();
    measure("R4", 64, 1089, 1, 17, 1);
    testMidLoad();
    loadN(1'b0, 1088);
    measure("R5", 64, 1088, 0, 17, 1);
    testPulseTiming();
    loadN(1'b0, 325);
    measure("R4", 64, 325, 5, 5, 1);
    testIllegal("R3", 1'b1, 1089);
    measure("R7", 64, 325, 5, 5, 1);
    testIllegal("R3", 1'b1, 2000);
    testIllegal("R3", 1'b0, 4031);
    loadN(1'b0, 4032);
    check("R7", "flag cleared by legal load", int'(illegal), 0);
    measure("R3", 64, 4032, 0, 63, 1);
    testIllegal("R3", 1'b1, 16255);
    loadN(1'b1, 16256);
    check("R3", "16256 accepted", int'(illegal), 0);
    measure("R3", 128, 16256, 0, 127, 0);
    testIllegal("R3", 1'b0, 200000);
    testIllegal("R3", 1'b0, 0);
    loadN(1'b1, 12837);
    measure("R2", 128, 12837, 37, 100, 1);
    loadN(1'b0, 64);
    measure("R9", 64, 64, 0, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule